// File: doc/BRIEF.md
# SPI Nonvolatile Memory Slave Controller

This block behaves like a small serial memory device sitting on an SPI bus in mode 0. After chip select goes low, the first eight bits received form an op-code, sent most significant bit first. That op-code selects one of six operations. Two operations set or clear a write-enable latch. Two read or write an 8-bit status register. Two read or write a byte-wide memory array held inside the block. The SPI pins are sampled with the system clock through a synchronizer, so all logic runs in one clock domain. The SPI clock must therefore be several times slower than the system clock.

The status register holds a write-protect-enable flag, three spare bits, a two-bit block-protect field and the write-enable latch. Together with the active-low write-protect pin, these decide whether a status write or a memory write takes effect. Memory accesses take a 16-bit address. Only the low `ADDR_BITS` bits of that address are used. Data then streams byte after byte, and the address increments and wraps at the top of the array.

Top module: `spi_mem_slave`

## Requirements
- R1: After reset the status register reads 0x00 and MISO is 0.
- R2: MOSI is sampled on SCLK rising edges and MISO changes on SCLK falling edges, MSB first. MISO is 0 while chip select is high. The op-codes are 0x06 latch set, 0x04 latch clear, 0x05 status read, 0x01 status write, 0x03 memory read and 0x02 memory write.
- R3: Op-code 0x06 sets the write-enable latch (status bit 1). Op-code 0x04 clears it.
- R4: A status read returns the status byte, and repeats it for every further byte clocked in that transaction. The byte is laid out as: bit 7 write-protect-enable, bits 6..4 spare, bits 3..2 block-protect, bit 1 latch, bit 0 always 0.
- R5: A status write with the latch set loads bits 7..2 from the data byte. Data bits 1..0 have no effect.
- R6: When chip select rises to end a status write or a memory write whose op-code was complete, the latch clears. This happens whether or not the write took effect.
- R7: A status write is ignored when the latch is 0. It is also ignored when bit 7 is 1 and the write-protect pin is low.
- R8: A memory write takes a 16-bit address, MSB first, and uses its low ADDR_BITS bits. Each data byte is stored only when the latch is set. The address increments after every byte and wraps from the top of the array to 0.
- R9: A memory read takes the same address form and returns the stored bytes in order. The address increments and wraps in the same way.
- R10: The block-protect field selects which writes are dropped: 00 none, 01 the top quarter of the array, 10 the top half, 11 the whole array. A dropped byte still advances the address.
- R11: If chip select rises before all eight op-code bits have arrived, the command has no effect.
- R12: After an unknown op-code, the rest of the transaction changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |
| wp_n | input | 1 | Active-low write-protect pin |

## Verification
The main function is tried with every op-code against both states of the latch. This separates a latch that gates writes from one that is only reported. Memory bursts start just below the top of the array and also carry stray upper address bits, which shows whether wrapping and address truncation happen at the right width. Each block-protect setting is paired with a burst that crosses its protection boundary, so an off-by-one boundary or a dropped address increment shows up as the wrong read-back byte. Truncated op-codes, an unknown op-code, and status writes made with the protect pin low and high test the cases where nothing may change.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  localparam logic [7:0] OP_LATCH_SET = 8'h06;
  localparam logic [7:0] OP_LATCH_CLR = 8'h04;
  localparam logic [7:0] OP_STAT_RD   = 8'h05;
  localparam logic [7:0] OP_STAT_WR   = 8'h01;
  localparam logic [7:0] OP_MEM_RD    = 8'h03;
  localparam logic [7:0] OP_MEM_WR    = 8'h02;

  typedef enum logic [2:0] {
    PH_OPCODE,
    PH_ADDR,
    PH_RD_DATA,
    PH_WR_DATA,
    PH_RD_STAT,
    PH_WR_STAT,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic mosi_s
);
  logic [STAGES-1:0] sclk_q, cs_q, mosi_q;
  logic              sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_q <= {sclk_q[STAGES-2:0], sclk};
      cs_q   <= {cs_q[STAGES-2:0], cs_n};
      mosi_q <= {mosi_q[STAGES-2:0], mosi};
      sclk_d <= sclk_q[STAGES-1];
    end
  end

  assign sclk_rise = sclk_q[STAGES-1] & ~sclk_d;
  assign sclk_fall = ~sclk_q[STAGES-1] & sclk_d;
  assign cs_act    = ~cs_q[STAGES-1];
  assign mosi_s    = mosi_q[STAGES-1];
endmodule

// File: rtl/spi_mem_status.sv
module spi_mem_status #(
  parameter int ADDR_BITS = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wp_n,
  input  logic                 set_wel,
  input  logic                 clr_wel,
  input  logic                 wr_stat,
  input  logic [5:0]           wr_bits,
  input  logic [ADDR_BITS-1:0] chk_addr,
  output logic [7:0]           status,
  output logic                 wel,
  output logic                 addr_locked
);
  logic       wpen;
  logic [2:0] spare;
  logic [1:0] bp;
  logic       stat_writable;
  logic [1:0] region;

  assign stat_writable = wel & ~(wpen & ~wp_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      wpen  <= 1'b0;
      spare <= 3'b000;
      bp    <= 2'b00;
      wel   <= 1'b0;
    end else begin
      if (wr_stat && stat_writable) begin
        wpen  <= wr_bits[5];
        spare <= wr_bits[4:2];
        bp    <= wr_bits[1:0];
      end
      if (set_wel)      wel <= 1'b1;
      else if (clr_wel) wel <= 1'b0;
    end
  end

  assign region = chk_addr[ADDR_BITS-1 -: 2];

  always_comb begin
    case (bp)
      2'b00:   addr_locked = 1'b0;
      2'b01:   addr_locked = (region == 2'b11);
      2'b10:   addr_locked = region[1];
      default: addr_locked = 1'b1;
    endcase
  end

  assign status = {wpen, spare, bp, wel, 1'b0};
endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
  parameter int ADDR_BITS = 10,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [ADDR_BITS-1:0] addr,
  input  logic [DATA_BITS-1:0] wdata,
  output logic [DATA_BITS-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_BITS;

  logic [DATA_BITS-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
  import spi_mem_pkg::*;
#(
  parameter int ADDR_BITS   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  input  logic wp_n
);
  localparam int          WIRE_ADDR = 16;
  localparam logic [15:0] ADDR_MASK = 16'((32'd1 << ADDR_BITS) - 1);

  logic        sclk_rise, sclk_fall, cs_act, mosi_s;
  phase_t      phase;
  logic [2:0]  bit_cnt;
  logic [6:0]  rx_sh;
  logic [7:0]  rx_byte;
  logic        byte_done;
  logic        addr_hi_done;
  logic [7:0]  addr_hi;
  logic [WIRE_ADDR-1:0] addr_w;
  logic [WIRE_ADDR-1:0] full_addr;
  logic        rd_cmd;
  logic        wel_drop_pend;
  logic        op_valid, set_wel, clr_wel, wr_stat, mem_we;
  logic [7:0]  status;
  logic        wel, addr_locked;
  logic [7:0]  mem_q;
  logic [6:0]  tx_sh;
  logic        miso_r;
  logic [7:0]  tx_src;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_act(cs_act), .mosi_s(mosi_s)
  );

  assign rx_byte   = {rx_sh, mosi_s};
  assign byte_done = cs_act && sclk_rise && (bit_cnt == 3'd7);
  assign op_valid  = byte_done && (phase == PH_OPCODE);
  assign set_wel   = op_valid && (rx_byte == OP_LATCH_SET);
  assign clr_wel   = (op_valid && (rx_byte == OP_LATCH_CLR)) || (!cs_act && wel_drop_pend);
  assign wr_stat   = byte_done && (phase == PH_WR_STAT);
  assign mem_we    = byte_done && (phase == PH_WR_DATA) && wel && !addr_locked;
  assign full_addr = {addr_hi, rx_byte};

  spi_mem_status #(.ADDR_BITS(ADDR_BITS)) u_status (
    .clk(clk), .rst(rst), .wp_n(wp_n),
    .set_wel(set_wel), .clr_wel(clr_wel), .wr_stat(wr_stat),
    .wr_bits(rx_byte[7:2]), .chk_addr(addr_w[ADDR_BITS-1:0]),
    .status(status), .wel(wel), .addr_locked(addr_locked)
  );

  spi_mem_array #(.ADDR_BITS(ADDR_BITS), .DATA_BITS(8)) u_array (
    .clk(clk), .we(mem_we), .addr(addr_w[ADDR_BITS-1:0]),
    .wdata(rx_byte), .rdata(mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase         <= PH_OPCODE;
      bit_cnt       <= 3'd0;
      rx_sh         <= 7'd0;
      addr_hi_done  <= 1'b0;
      addr_hi       <= 8'd0;
      addr_w        <= '0;
      rd_cmd        <= 1'b0;
      wel_drop_pend <= 1'b0;
    end else if (!cs_act) begin
      phase         <= PH_OPCODE;
      bit_cnt       <= 3'd0;
      addr_hi_done  <= 1'b0;
      wel_drop_pend <= 1'b0;
    end else begin
      if (sclk_rise) begin
        rx_sh   <= rx_byte[6:0];
        bit_cnt <= bit_cnt + 3'd1;
      end
      if (byte_done) begin
        case (phase)
          PH_OPCODE: begin
            case (rx_byte)
              OP_STAT_RD: phase <= PH_RD_STAT;
              OP_STAT_WR: begin
                phase         <= PH_WR_STAT;
                wel_drop_pend <= 1'b1;
              end
              OP_MEM_RD: begin
                phase  <= PH_ADDR;
                rd_cmd <= 1'b1;
              end
              OP_MEM_WR: begin
                phase         <= PH_ADDR;
                rd_cmd        <= 1'b0;
                wel_drop_pend <= 1'b1;
              end
              default: phase <= PH_SKIP;
            endcase
          end
          PH_ADDR: begin
            if (!addr_hi_done) begin
              addr_hi      <= rx_byte;
              addr_hi_done <= 1'b1;
            end else begin
              addr_w <= full_addr & ADDR_MASK;
              phase  <= rd_cmd ? PH_RD_DATA : PH_WR_DATA;
            end
          end
          PH_RD_DATA, PH_WR_DATA: addr_w <= (addr_w + 16'd1) & ADDR_MASK;
          PH_WR_STAT: phase <= PH_SKIP;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (phase)
      PH_RD_STAT: tx_src = status;
      PH_RD_DATA: tx_src = mem_q;
      default:    tx_src = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      miso_r <= 1'b0;
      tx_sh  <= 7'd0;
    end else if (sclk_fall) begin
      if (bit_cnt == 3'd0) {miso_r, tx_sh} <= tx_src;
      else                 {miso_r, tx_sh} <= {tx_sh, 1'b0};
    end
  end

  assign spi_miso = miso_r;
endmodule

// File: rtl/spi_mem_slave_chk.sv
module spi_mem_slave_chk
  import spi_mem_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       cs_act,
  input logic       miso,
  input phase_t     phase,
  input logic       op_valid,
  input logic [7:0] op_byte,
  input logic       wel,
  input logic       wel_drop_pend,
  input logic       wr_stat,
  input logic       wp_n,
  input logic [7:0] status,
  input logic       byte_done,
  input logic       mem_we
);
  p_miso_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !miso);

  p_latch_set_r3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_byte == OP_LATCH_SET) |=> wel);

  p_latch_clr_r3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_byte == OP_LATCH_CLR) |=> !wel);

  p_latch_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (wel_drop_pend && !cs_act) |=> !wel);

  p_pin_guard_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && status[7] && !wp_n) |=> $stable(status[7:2]));

  p_latch_guard_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && !wel) |=> $stable(status[7:2]));

  p_full_lock_r10: assert property (@(posedge clk) disable iff (rst)
    (byte_done && phase == PH_WR_DATA && status[3:2] == 2'b11) |-> !mem_we);

  p_abort_r11: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_OPCODE && !cs_act) |=> $stable(status));
endmodule

bind spi_mem_slave spi_mem_slave_chk u_chk (
  .clk(clk), .rst(rst), .cs_act(cs_act), .miso(spi_miso), .phase(phase),
  .op_valid(op_valid), .op_byte(rx_byte), .wel(wel),
  .wel_drop_pend(wel_drop_pend), .wr_stat(wr_stat), .wp_n(wp_n),
  .status(status), .byte_done(byte_done), .mem_we(mem_we)
);

// File: tb/spi_mem_slave_test.sv
module spi_mem_slave_test;
  localparam int ADDR_BITS = 10;
  localparam int DEPTH     = 1 << ADDR_BITS;
  localparam int HALF      = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1;
  logic miso;

  int checks = 0;
  int errors = 0;
  int cs_hi_cnt = 0;
  bit done = 1'b0;

  bit       m_wpen;
  bit [2:0] m_spare;
  bit [1:0] m_bp;
  bit       m_wel;
  byte unsigned m_mem [int];

  always #2 clk = ~clk;

  spi_mem_slave #(.ADDR_BITS(ADDR_BITS), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .wp_n(wp_n)
  );

  function automatic logic [7:0] m_status();
    return {m_wpen, m_spare, m_bp, m_wel, 1'b0};
  endfunction

  function automatic bit m_locked(int a);
    int top = a >> (ADDR_BITS - 2);
    case (m_bp)
      2'd0: return 1'b0;
      2'd1: return top == 3;
      2'd2: return top >= 2;
      default: return 1'b1;
    endcase
  endfunction

  task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // R2: MISO must stay 0 while chip select has been high for a while
  always @(negedge clk) begin
    if (!rst && cs_hi_cnt > 6) begin
      checks++;
      if (miso !== 1'b0) begin
        errors++;
        $display("FAIL R2: idle miso actual %b expected 0", miso);
      end
    end
    cs_hi_cnt = cs_n ? cs_hi_cnt + 1 : 0;
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic xfer_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = tx[i];
      tick(HALF);
      rx[i] = miso;
      sclk = 1'b1;
      tick(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    xfer_bits(tx, 8, rx);
  endtask

  task automatic open_cs();
    cs_n = 1'b0;
    tick(HALF);
  endtask

  task automatic close_cs();
    tick(HALF);
    cs_n = 1'b1;
    tick(2 * HALF);
  endtask

  task automatic cmd_simple(logic [7:0] op);
    logic [7:0] r;
    open_cs();
    xfer(op, r);
    close_cs();
    if (op == 8'h06) m_wel = 1'b1;
    if (op == 8'h04) m_wel = 1'b0;
  endtask

  task automatic cmd_rdsr(string req);
    logic [7:0] r;
    open_cs();
    xfer(8'h05, r);
    xfer(8'h00, r);
    check8(req, r, m_status());
    xfer(8'h00, r);
    check8({req, " R4 repeat"}, r, m_status());
    close_cs();
  endtask

  task automatic cmd_wrsr(logic [7:0] d);
    logic [7:0] r;
    open_cs();
    xfer(8'h01, r);
    xfer(d, r);
    close_cs();
    if (m_wel && !(m_wpen && !wp_n)) begin
      m_wpen  = d[7];
      m_spare = d[6:4];
      m_bp    = d[3:2];
    end
    m_wel = 1'b0;
  endtask

  task automatic cmd_write(logic [15:0] a, int n, logic [7:0] base);
    logic [7:0] r;
    int ia = int'(a) % DEPTH;
    open_cs();
    xfer(8'h02, r);
    xfer(a[15:8], r);
    xfer(a[7:0], r);
    for (int i = 0; i < n; i++) begin
      xfer(base + 8'(i), r);
      if (m_wel && !m_locked(ia)) m_mem[ia] = base + 8'(i);
      ia = (ia + 1) % DEPTH;
    end
    close_cs();
    m_wel = 1'b0;
  endtask

  task automatic cmd_read(logic [15:0] a, int n, string req);
    logic [7:0] r;
    int ia = int'(a) % DEPTH;
    open_cs();
    xfer(8'h03, r);
    xfer(a[15:8], r);
    xfer(a[7:0], r);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, r);
      if (m_mem.exists(ia)) check8(req, r, m_mem[ia]);
      ia = (ia + 1) % DEPTH;
    end
    close_cs();
  endtask

  initial begin
    logic [7:0] r;
    tick(10);
    rst = 1'b0;
    tick(4);
    // R1: reset state
    check8("R1 miso", {7'd0, miso}, 8'h00);
    cmd_rdsr("R1 status");

    // R8: write without latch is dropped, then real writes incl. wrap and upper address bits
    cmd_write(16'h0010, 2, 8'h11);
    cmd_simple(8'h06);
    cmd_write(16'h0010, 4, 8'hA0);
    cmd_rdsr("R6 latch after write");
    cmd_simple(8'h06);
    cmd_write(16'(DEPTH - 2), 4, 8'h50);
    cmd_simple(8'h06);
    cmd_write(16'hFC00 | 16'h0100, 2, 8'h70);
    cmd_simple(8'h06);
    cmd_write(16'h0200, 2, 8'h80);
    cmd_read(16'h0010, 4, "R9 read burst");
    cmd_read(16'(DEPTH - 2), 4, "R9 wrap read");
    cmd_read(16'h0100, 2, "R8 upper bits ignored");
    cmd_read(16'h0200, 2, "R8 mid array");

    // R3: latch set and clear
    cmd_simple(8'h06);
    cmd_rdsr("R3 latch set");
    cmd_simple(8'h04);
    cmd_rdsr("R3 latch clear");

    // R5: status write, low bits ignored
    cmd_simple(8'h06);
    cmd_wrsr(8'h73);
    cmd_rdsr("R5 spare bits");
    // R7: status write without latch
    cmd_wrsr(8'h0C);
    cmd_rdsr("R7 no latch");

    // R7: pin protection
    cmd_simple(8'h06);
    cmd_wrsr(8'h80);
    wp_n = 1'b0;
    cmd_simple(8'h06);
    cmd_wrsr(8'h8C);
    cmd_rdsr("R7 pin low blocks R6");
    wp_n = 1'b1;
    cmd_simple(8'h06);
    cmd_wrsr(8'h8C);
    cmd_rdsr("R7 pin high allows");

    // R10: whole array protected
    cmd_simple(8'h06);
    cmd_write(16'h0100, 2, 8'hEE);
    cmd_read(16'h0100, 2, "R10 all locked");
    // R10: top quarter
    cmd_simple(8'h06);
    cmd_wrsr(8'h84);
    cmd_simple(8'h06);
    cmd_write(16'(DEPTH - 2), 4, 8'hC0);
    cmd_read(16'(DEPTH - 2), 4, "R10 quarter");
    // R10: top half
    cmd_simple(8'h06);
    cmd_wrsr(8'h88);
    cmd_simple(8'h06);
    cmd_write(16'(DEPTH / 2 - 1), 2, 8'h30);
    cmd_read(16'(DEPTH / 2 - 1), 2, "R10 half");
    cmd_rdsr("R10 status");

    // R11: truncated op-code
    open_cs();
    xfer_bits(8'h06, 5, r);
    close_cs();
    cmd_rdsr("R11 abort set");
    cmd_simple(8'h06);
    open_cs();
    xfer_bits(8'h04, 7, r);
    close_cs();
    cmd_rdsr("R11 abort clear");

    // R12: unknown op-code followed by bytes looking like commands
    open_cs();
    xfer(8'hAB, r);
    xfer(8'h04, r);
    xfer(8'h01, r);
    xfer(8'h00, r);
    close_cs();
    cmd_rdsr("R12 unknown op");
    cmd_simple(8'h04);
    cmd_rdsr("R3 final clear");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule